// File: doc/BRIEF.md
# Set/Reset Differential Measurement Sequencer

This block runs one three-axis magnetic measurement and produces one result per axis. It drives the strap controls of an analog front end: a set pulse, a reset pulse, and an offset-strap enable with a polarity bit. It also asks the front end for conversions through a request/acknowledge data port. Each conversion request names one axis and carries the gain to use.

Every result is the difference of two conversions of the same axis. In the normal flow the block takes the first conversion after a set pulse and the second after a reset pulse, and keeps half their difference. This removes the bridge offset. In the self-test flows the block converts once after the set pulse, drives the offset strap with the chosen polarity, converts again, and keeps the second conversion minus the first. The block can average 1, 2, 4 or 8 such differences. Any overflow in the path replaces that axis's result with a fixed sentinel value.

The block writes the three results to an external result-register file through a write strobe. It then raises a done pulse. A cycle is started either by a one-shot request or, in continuous operation, by a rate tick.

Top module: `sr_meas_seq`

## Requirements
- R1: With the measurement field at 00 (normal), each sample works as follows. A one-cycle set pulse is followed by one conversion per axis. A one-cycle reset pulse is then followed by a second conversion per axis. The sample for each axis is (first − second) shifted right arithmetically by one bit. The offset strap stays off throughout.
- R2: With the field at 01 or 10 (self-test), each sample works as follows. A one-cycle set pulse is followed by one conversion per axis. The offset-strap enable is then raised and held through a second conversion per axis. The polarity output is 0 for 01 and 1 for 10. The sample is second − first. No reset pulse is issued.
- R3: An overflow flag returned with any conversion of an axis makes that axis's written result −4096. The next cycle without a flagged conversion writes a normal value again.
- R4: In self-test, a difference outside −2048..2047 makes that axis's written result −4096.
- R5: The averaging field 00/01/10/11 selects 1/2/4/8 samples per output. The written value is the sum of the samples shifted right arithmetically by 0/1/2/3 bits.
- R6: With the field at 11 (temperature only), a started cycle issues no strap pulses, no conversion requests and no result writes. It still raises done.
- R7: Within each half-sample, conversions are requested in axis order X, Z, Y. Axis codes are X=0, Y=1, Z=2. Results are written in the order X, Z, Y on three consecutive cycles, and done is high on the cycle after the Y write.
- R8: The gain sent with the conversions of a cycle is the gain input as sampled at the start of the previous cycle. A change therefore first applies to the second cycle after it.
- R9: With the operation field at 01 (single), a start pulse runs one cycle. The idle write-back strobe is raised together with done.
- R10: With the operation field at 00 (continuous), each rate tick that arrives while the block is free starts a cycle. No idle write-back is issued.
- R11: The block ignores start pulses and rate ticks that arrive while a cycle is running. With the operation field at 10 or 11 it ignores them at all times: no conversions and no done follow.
- R12: A conversion request stays high with a stable axis code until it is acknowledged.
- R13: After reset, all outputs are low and no cycle runs. The gain used by the first cycle is the default gain 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-shot cycle request (single operation) |
| rate_tick_i | input | 1 | Output-rate tick (continuous operation) |
| op_mode_i | input | 2 | 00 continuous, 01 single, 1x idle |
| meas_cfg_i | input | 2 | 00 normal, 01 positive bias, 10 negative bias, 11 temperature only |
| avg_cfg_i | input | 2 | Averaging select, 2^value samples |
| gain_cfg_i | input | GAIN_W | Requested gain code |
| set_pulse_o | output | 1 | Set strap pulse |
| reset_pulse_o | output | 1 | Reset strap pulse |
| bias_en_o | output | 1 | Offset strap enable |
| bias_neg_o | output | 1 | Offset strap polarity, 1 = negative |
| conv_req_o | output | 1 | Conversion request |
| conv_axis_o | output | 2 | Axis of the requested conversion |
| conv_gain_o | output | GAIN_W | Gain applied to conversions |
| conv_ack_i | input | 1 | Conversion returned |
| conv_data_i | input | ADC_W | Signed conversion value |
| conv_ovf_i | input | 1 | Conversion over/underflow |
| res_we_o | output | 1 | Result write strobe |
| res_axis_o | output | 2 | Axis of the written result |
| res_data_o | output | OUT_W | Signed result |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | Cycle finished pulse |
| mode_idle_wr_o | output | 1 | Request to set the operation field to idle |

## Verification
The bench builds the block with its defaults: a 12-bit converter, 16-bit results and a 3-bit gain. At this size the whole grid of measurement flows, averaging counts and both operation modes can be swept.

A small front-end model returns values spread over ±800, which gives exact averaged results with no overflow. A second data set alternates ±2000. In the normal flow this gives large valid results, and in self-test it forces the subtraction to overflow. Overflow flags are also injected on chosen conversions. The gain code is rotated on every cycle, so the one-cycle delay of a gain change is checked on each cycle.

// File: rtl/msq_pkg.sv
package msq_pkg;

    localparam int AXES        = 3;
    localparam int AVG_W       = 2;
    localparam int AVG_LOG_MAX = (1 << AVG_W) - 1;

    typedef enum logic [1:0] {
        AX_X = 2'd0,
        AX_Y = 2'd1,
        AX_Z = 2'd2
    } axis_e;

    typedef enum logic [1:0] {
        MF_NORMAL   = 2'd0,
        MF_BIAS_POS = 2'd1,
        MF_BIAS_NEG = 2'd2,
        MF_TEMP     = 2'd3
    } meas_e;

    typedef enum logic [1:0] {
        OP_CONT   = 2'd0,
        OP_SINGLE = 2'd1,
        OP_IDLE_A = 2'd2,
        OP_IDLE_B = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SET,
        S_CONV1,
        S_FLIP,
        S_CONV2,
        S_WRITE,
        S_FIN
    } state_e;

    typedef struct packed {
        logic set_p;
        logic rst_p;
        logic bias_en;
        logic bias_neg;
    } strap_t;

    // conversion and write order within a phase: X, Z, Y
    function automatic axis_e slot_axis(input logic [1:0] slot);
        case (slot)
            2'd0:    return AX_X;
            2'd1:    return AX_Z;
            default: return AX_Y;
        endcase
    endfunction

    function automatic logic is_bias(input meas_e m);
        return (m == MF_BIAS_POS) || (m == MF_BIAS_NEG);
    endfunction

endpackage

// File: rtl/msq_gain_lag.sv
module msq_gain_lag #(
    parameter int               GAIN_W   = 3,
    parameter logic [GAIN_W-1:0] GAIN_RST = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch_i,
    input  logic [GAIN_W-1:0] gain_req_i,
    output logic [GAIN_W-1:0] gain_use_o
);
    logic [GAIN_W-1:0] lag_q;
    logic [GAIN_W-1:0] use_q;

    // a cycle applies the gain captured at the previous launch
    always_ff @(posedge clk) begin
        if (rst) begin
            lag_q <= GAIN_RST;
            use_q <= GAIN_RST;
        end else if (launch_i) begin
            use_q <= lag_q;
            lag_q <= gain_req_i;
        end
    end

    assign gain_use_o = use_q;
endmodule

// File: rtl/msq_axis.sv
module msq_axis import msq_pkg::*; #(
    parameter int ADC_W = 12,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr_i,
    input  logic                    cap1_i,
    input  logic                    cap2_i,
    input  logic                    bias_mode_i,
    input  logic [AVG_W-1:0]        avg_i,
    input  logic signed [ADC_W-1:0] data_i,
    input  logic                    ovf_i,
    output logic signed [OUT_W-1:0] result_o
);
    localparam int DIFF_W = ADC_W + 1;
    localparam int ACC_W  = DIFF_W + AVG_LOG_MAX;
    localparam logic signed [DIFF_W-1:0] LIM_HI = DIFF_W'((2 ** (ADC_W - 1)) - 1);
    localparam logic signed [DIFF_W-1:0] LIM_LO = DIFF_W'(-(2 ** (ADC_W - 1)));
    localparam logic signed [OUT_W-1:0]  SENT   = OUT_W'(-(2 ** ADC_W));

    logic signed [DIFF_W-1:0] data_x;
    logic signed [DIFF_W-1:0] m1_q;
    logic signed [DIFF_W-1:0] d_raw;
    logic signed [DIFF_W-1:0] d_val;
    logic                     oob;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  avg_res;
    logic                     err_q;

    assign data_x = DIFF_W'(data_i);

    always_comb begin
        d_raw = bias_mode_i ? (data_x - m1_q) : (m1_q - data_x);
        d_val = bias_mode_i ? d_raw : (d_raw >>> 1);
        oob   = bias_mode_i && ((d_raw > LIM_HI) || (d_raw < LIM_LO));
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            m1_q  <= '0;
            acc_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (cap1_i) begin
                m1_q <= data_x;
                if (ovf_i) err_q <= 1'b1;
            end
            if (cap2_i) begin
                acc_q <= acc_q + ACC_W'(d_val);
                if (ovf_i || oob) err_q <= 1'b1;
            end
        end
    end

    assign avg_res  = acc_q >>> avg_i;
    assign result_o = err_q ? SENT : OUT_W'(avg_res);
endmodule

// File: rtl/msq_ctrl.sv
module msq_ctrl import msq_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic [1:0]       op_i,
    input  logic [1:0]       meas_i,
    input  logic [AVG_W-1:0] avg_i,
    input  logic             ack_i,
    output logic             launch_o,
    output strap_t           strap_o,
    output logic             conv_req_o,
    output axis_e            conv_axis_o,
    output logic             cap1_o,
    output logic             cap2_o,
    output logic             bias_mode_o,
    output logic [AVG_W-1:0] avg_o,
    output logic             res_we_o,
    output axis_e            res_axis_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             idle_wr_o
);
    localparam int SMP_W = AVG_LOG_MAX;

    state_e            state_q;
    logic [1:0]        slot_q;
    logic [SMP_W-1:0]  smp_q;
    logic [SMP_W-1:0]  smp_last;
    meas_e             meas_q;
    logic [AVG_W-1:0]  avg_q;
    logic              single_q;
    logic              launch;

    assign launch = (state_q == S_IDLE) &&
                    (((op_e'(op_i) == OP_SINGLE) && start_i) ||
                     ((op_e'(op_i) == OP_CONT) && tick_i));
    assign smp_last = (SMP_W'(1) << avg_q) - SMP_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            slot_q   <= '0;
            smp_q    <= '0;
            meas_q   <= MF_NORMAL;
            avg_q    <= '0;
            single_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (launch) begin
                    meas_q   <= meas_e'(meas_i);
                    avg_q    <= avg_i;
                    single_q <= (op_e'(op_i) == OP_SINGLE);
                    smp_q    <= '0;
                    slot_q   <= '0;
                    state_q  <= (meas_e'(meas_i) == MF_TEMP) ? S_FIN : S_SET;
                end
                S_SET: begin
                    slot_q  <= '0;
                    state_q <= S_CONV1;
                end
                S_CONV1: if (ack_i) begin
                    if (slot_q == 2'd2) begin
                        slot_q  <= '0;
                        state_q <= S_FLIP;
                    end else begin
                        slot_q <= slot_q + 2'd1;
                    end
                end
                S_FLIP: state_q <= S_CONV2;
                S_CONV2: if (ack_i) begin
                    if (slot_q == 2'd2) begin
                        slot_q <= '0;
                        if (smp_q == smp_last) begin
                            state_q <= S_WRITE;
                        end else begin
                            smp_q   <= smp_q + SMP_W'(1);
                            state_q <= S_SET;
                        end
                    end else begin
                        slot_q <= slot_q + 2'd1;
                    end
                end
                S_WRITE: begin
                    if (slot_q == 2'd2) begin
                        slot_q  <= '0;
                        state_q <= S_FIN;
                    end else begin
                        slot_q <= slot_q + 2'd1;
                    end
                end
                S_FIN:   state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        bias_mode_o      = is_bias(meas_q);
        strap_o.set_p    = (state_q == S_SET);
        strap_o.rst_p    = (state_q == S_FLIP) && !bias_mode_o;
        strap_o.bias_en  = bias_mode_o && ((state_q == S_FLIP) || (state_q == S_CONV2));
        strap_o.bias_neg = strap_o.bias_en && (meas_q == MF_BIAS_NEG);
        conv_req_o       = (state_q == S_CONV1) || (state_q == S_CONV2);
        conv_axis_o      = slot_axis(slot_q);
        cap1_o           = (state_q == S_CONV1) && ack_i;
        cap2_o           = (state_q == S_CONV2) && ack_i;
        res_we_o         = (state_q == S_WRITE);
        res_axis_o       = slot_axis(slot_q);
        busy_o           = (state_q != S_IDLE);
        done_o           = (state_q == S_FIN);
        idle_wr_o        = (state_q == S_FIN) && single_q;
        avg_o            = avg_q;
        launch_o         = launch;
    end
endmodule

// File: rtl/sr_meas_seq.sv
module sr_meas_seq import msq_pkg::*; #(
    parameter int                ADC_W    = 12,
    parameter int                OUT_W    = 16,
    parameter int                GAIN_W   = 3,
    parameter logic [GAIN_W-1:0] GAIN_RST = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              rate_tick_i,
    input  logic [1:0]        op_mode_i,
    input  logic [1:0]        meas_cfg_i,
    input  logic [1:0]        avg_cfg_i,
    input  logic [GAIN_W-1:0] gain_cfg_i,
    output logic              set_pulse_o,
    output logic              reset_pulse_o,
    output logic              bias_en_o,
    output logic              bias_neg_o,
    output logic              conv_req_o,
    output logic [1:0]        conv_axis_o,
    output logic [GAIN_W-1:0] conv_gain_o,
    input  logic              conv_ack_i,
    input  logic [ADC_W-1:0]  conv_data_i,
    input  logic              conv_ovf_i,
    output logic              res_we_o,
    output logic [1:0]        res_axis_o,
    output logic [OUT_W-1:0]  res_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              mode_idle_wr_o
);
    logic             launch;
    strap_t           strap;
    axis_e            c_axis;
    axis_e            w_axis;
    logic             cap1;
    logic             cap2;
    logic             bias_mode;
    logic [AVG_W-1:0] avg_q;
    logic signed [OUT_W-1:0] axis_res [AXES];

    msq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .tick_i     (rate_tick_i),
        .op_i       (op_mode_i),
        .meas_i     (meas_cfg_i),
        .avg_i      (avg_cfg_i),
        .ack_i      (conv_ack_i),
        .launch_o   (launch),
        .strap_o    (strap),
        .conv_req_o (conv_req_o),
        .conv_axis_o(c_axis),
        .cap1_o     (cap1),
        .cap2_o     (cap2),
        .bias_mode_o(bias_mode),
        .avg_o      (avg_q),
        .res_we_o   (res_we_o),
        .res_axis_o (w_axis),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .idle_wr_o  (mode_idle_wr_o)
    );

    msq_gain_lag #(.GAIN_W(GAIN_W), .GAIN_RST(GAIN_RST)) u_gain (
        .clk       (clk),
        .rst       (rst),
        .launch_i  (launch),
        .gain_req_i(gain_cfg_i),
        .gain_use_o(conv_gain_o)
    );

    for (genvar i = 0; i < AXES; i++) begin : g_axis
        msq_axis #(.ADC_W(ADC_W), .OUT_W(OUT_W)) u_axis (
            .clk        (clk),
            .rst        (rst),
            .clr_i      (launch),
            .cap1_i     (cap1 && (c_axis == axis_e'(i))),
            .cap2_i     (cap2 && (c_axis == axis_e'(i))),
            .bias_mode_i(bias_mode),
            .avg_i      (avg_q),
            .data_i     (conv_data_i),
            .ovf_i      (conv_ovf_i),
            .result_o   (axis_res[i])
        );
    end

    always_comb begin
        res_data_o = '0;
        for (int i = 0; i < AXES; i++) begin
            if (w_axis == axis_e'(i)) res_data_o = axis_res[i];
        end
    end

    assign set_pulse_o   = strap.set_p;
    assign reset_pulse_o = strap.rst_p;
    assign bias_en_o     = strap.bias_en;
    assign bias_neg_o    = strap.bias_neg;
    assign conv_axis_o   = c_axis;
    assign res_axis_o    = w_axis;
endmodule

// File: rtl/msq_chk.sv
module msq_chk #(
    parameter int ADC_W  = 12,
    parameter int OUT_W  = 16,
    parameter int GAIN_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              set_pulse_o,
    input logic              reset_pulse_o,
    input logic              bias_en_o,
    input logic              conv_req_o,
    input logic [1:0]        conv_axis_o,
    input logic [GAIN_W-1:0] conv_gain_o,
    input logic              conv_ack_i,
    input logic              res_we_o,
    input logic [1:0]        res_axis_o,
    input logic [OUT_W-1:0]  res_data_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              mode_idle_wr_o
);
    localparam logic signed [OUT_W-1:0] HI   = OUT_W'((2 ** (ADC_W - 1)) - 1);
    localparam logic signed [OUT_W-1:0] LO   = OUT_W'(-(2 ** (ADC_W - 1)));
    localparam logic signed [OUT_W-1:0] SENT = OUT_W'(-(2 ** ADC_W));

    // R1: set strobe lasts exactly one cycle
    a_r1_set_one_cycle: assert property (@(posedge clk) disable iff (rst)
        set_pulse_o |=> !set_pulse_o);

    // R2: offset strap never overlaps set or reset strobes
    a_r2_bias_alone: assert property (@(posedge clk) disable iff (rst)
        bias_en_o |-> (!reset_pulse_o && !set_pulse_o));

    // R12: request held with stable axis until acknowledged
    a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
        (conv_req_o && !conv_ack_i) |=> (conv_req_o && $stable(conv_axis_o)));

    // R7: done follows the Y write
    a_r7_done_after_y: assert property (@(posedge clk) disable iff (rst)
        (res_we_o && (res_axis_o == 2'd1)) |=> done_o);

    // R3: written results are in range or the sentinel
    a_r3_result_range: assert property (@(posedge clk) disable iff (rst)
        res_we_o |-> (($signed(res_data_o) <= HI && $signed(res_data_o) >= LO) ||
                      ($signed(res_data_o) == SENT)));

    // R8: applied gain does not move inside a cycle
    a_r8_gain_stable: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(conv_gain_o));

    // R9: idle write-back only alongside done
    a_r9_idle_with_done: assert property (@(posedge clk) disable iff (rst)
        mode_idle_wr_o |-> done_o);

    // R11: a finished cycle leaves the block free
    a_r11_free_after_done: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);
endmodule

bind sr_meas_seq msq_chk #(.ADC_W(ADC_W), .OUT_W(OUT_W), .GAIN_W(GAIN_W)) u_chk (.*);

// File: tb/sr_meas_seq_test.sv
`timescale 1ns/1ps
module sr_meas_seq_test;
    localparam int ADC_W = 12;
    localparam int OUT_W = 16;
    localparam int GAIN_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, rate_tick_i = 1'b0;
    logic [1:0] op_mode_i = 2'd1, meas_cfg_i = 2'd0, avg_cfg_i = 2'd0;
    logic [GAIN_W-1:0] gain_cfg_i = '0;
    logic set_pulse_o, reset_pulse_o, bias_en_o, bias_neg_o, conv_req_o;
    logic [1:0] conv_axis_o;
    logic [GAIN_W-1:0] conv_gain_o;
    logic conv_ack_i = 1'b0;
    logic [ADC_W-1:0] conv_data_i = '0;
    logic conv_ovf_i = 1'b0;
    logic res_we_o;
    logic [1:0] res_axis_o;
    logic [OUT_W-1:0] res_data_o;
    logic busy_o, done_o, mode_idle_wr_o;

    always #4 clk = ~clk;

    sr_meas_seq uut (.*);

    int tests = 0, fails = 0;
    bit finished = 0;

    // front-end model state and logs
    int  gk = 0, nlog = 0, wcnt = 0;
    bit  big_mode = 0;
    int  ovf_at = -1;
    int  log_d [48];
    int  log_ax [48];
    int  log_g [48];
    bit  log_o [48];
    bit  log_b [48];

    // monitor state
    int  n_set, n_rst, n_bias, n_badpol, n_wr, n_done, n_idle, n_done_nowr;
    bit  exp_neg, prev_wy;
    int  wr_ax [4];
    int  wr_d [4];

    int lag_g = 1, use_g = 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic clear_mon();
        n_set = 0; n_rst = 0; n_bias = 0; n_badpol = 0; n_wr = 0;
        n_done = 0; n_idle = 0; n_done_nowr = 0; nlog = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    // front-end responder
    initial begin
        forever begin
            @(negedge clk);
            if (conv_ack_i) begin
                conv_ack_i = 0; conv_ovf_i = 0; wcnt = 0;
            end else if (conv_req_o && !rst) begin
                if (wcnt >= gk % 3) begin
                    int v;
                    if (big_mode) v = (nlog % 2 == 1) ? 2000 : -2000;
                    else v = ((gk * 173 + 29) % 1601) - 800;
                    conv_data_i = ADC_W'(v);
                    conv_ovf_i  = (nlog == ovf_at);
                    conv_ack_i  = 1;
                    if (nlog < 48) begin
                        log_d[nlog]  = v;
                        log_ax[nlog] = int'(conv_axis_o);
                        log_g[nlog]  = int'(conv_gain_o);
                        log_o[nlog]  = conv_ovf_i;
                        log_b[nlog]  = bias_en_o;
                    end
                    nlog++; gk++;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // output monitor
    initial begin
        prev_wy = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (set_pulse_o) n_set++;
                if (reset_pulse_o) n_rst++;
                if (bias_en_o) begin
                    n_bias++;
                    if (bias_neg_o != exp_neg) n_badpol++;
                end
                if (res_we_o) begin
                    if (n_wr < 4) begin
                        wr_ax[n_wr] = int'(res_axis_o);
                        wr_d[n_wr]  = int'($signed(res_data_o));
                    end
                    n_wr++;
                end
                if (done_o) begin
                    n_done++;
                    if (!prev_wy) n_done_nowr++;
                end
                if (mode_idle_wr_o) n_idle++;
                prev_wy = res_we_o && (res_axis_o == 2'd1);
            end
        end
    end

    function automatic int slot_code(input int j);
        return (j == 0) ? 0 : ((j == 1) ? 2 : 1);
    endfunction

    function automatic int exp_val(input int j, input int meas, input int avg);
        int sum = 0;
        bit err = 0;
        for (int s = 0; s < (1 << avg); s++) begin
            int a = log_d[s * 6 + j];
            int b = log_d[s * 6 + 3 + j];
            if (log_o[s * 6 + j] || log_o[s * 6 + 3 + j]) err = 1;
            if (meas == 0) sum += (a - b) >>> 1;
            else begin
                int d = b - a;
                if (d > 2047 || d < -2048) err = 1;
                sum += d;
            end
        end
        return err ? -4096 : (sum >>> avg);
    endfunction

    task automatic run_cycle(input int meas, input int avg, input int g, input int op,
                             input bit big, input int ovf_idx, input bit poke);
        int nsm;
        string vtag;
        meas_cfg_i = 2'(meas); avg_cfg_i = 2'(avg); gain_cfg_i = GAIN_W'(g);
        op_mode_i = 2'(op); big_mode = big; ovf_at = ovf_idx;
        exp_neg = (meas == 2);
        clear_mon();
        use_g = lag_g; lag_g = g;
        @(negedge clk);
        if (op == 0) rate_tick_i = 1; else start_i = 1;
        @(negedge clk);
        rate_tick_i = 0; start_i = 0;
        if (poke) begin
            repeat (3) @(negedge clk);
            start_i = 1; rate_tick_i = 1; gain_cfg_i = GAIN_W'(g + 3);
            @(negedge clk);
            start_i = 0; rate_tick_i = 0;
        end
        while (n_done == 0) @(negedge clk);
        repeat (2) @(negedge clk);
        nsm = 1 << avg;
        chk(n_done == 1, "R7 done count", n_done, 1);
        chk(n_idle == ((op == 1) ? 1 : 0), (op == 1) ? "R9 idle write-back" : "R10 no write-back",
            n_idle, (op == 1) ? 1 : 0);
        if (meas == 3) begin
            chk(nlog == 0 && n_wr == 0 && n_set == 0 && n_rst == 0 && n_bias == 0,
                "R6 temp-only activity", nlog + n_wr + n_set + n_rst + n_bias, 0);
        end else begin
            int bad_ax = 0, bad_g = 0, bad_b = 0;
            chk(nlog == 6 * nsm, "R5 conversion count", nlog, 6 * nsm);
            for (int i = 0; i < nlog && i < 48; i++) begin
                if (log_ax[i] != slot_code(i % 3)) bad_ax++;
                if (log_g[i] != use_g) bad_g++;
                if (meas != 0 && log_b[i] != ((i % 6) >= 3)) bad_b++;
            end
            chk(bad_ax == 0, "R7 conversion order", bad_ax, 0);
            chk(bad_g == 0, "R8 applied gain", (nlog > 0) ? log_g[0] : -1, use_g);
            chk(n_done_nowr == 0, "R7 done after Y write", n_done_nowr, 0);
            if (meas == 0) begin
                chk(n_set == nsm && n_rst == nsm && n_bias == 0, "R1 strap pulses",
                    n_set * 100 + n_rst * 10 + n_bias, nsm * 110);
            end else begin
                chk(n_set == nsm && n_rst == 0 && n_badpol == 0 && bad_b == 0 && n_bias > 0,
                    "R2 bias strap", n_rst + n_badpol + bad_b, 0);
            end
            chk(n_wr == 3, "R7 write count", n_wr, 3);
            if (ovf_idx >= 0) vtag = "R3 sentinel";
            else if (big && meas != 0) vtag = "R4 bias overflow";
            else if (avg > 0) vtag = "R5 average";
            else if (meas == 0) vtag = "R1 set-reset half";
            else vtag = "R2 bias difference";
            for (int j = 0; j < 3 && j < n_wr; j++) begin
                int e = exp_val(j, meas, avg);
                chk(wr_ax[j] == slot_code(j), "R7 write axis", wr_ax[j], slot_code(j));
                chk(wr_d[j] == e, vtag, wr_d[j], e);
            end
        end
        if (poke) begin
            clear_mon();
            repeat (40) @(negedge clk);
            chk(nlog == 0 && n_done == 0 && !busy_o, "R11 busy start ignored", nlog + n_done, 0);
        end
    endtask

    initial begin
        clear_mon();
        repeat (4) @(negedge clk);
        chk(!set_pulse_o && !reset_pulse_o && !bias_en_o && !conv_req_o && !res_we_o &&
            !busy_o && !done_o && !mode_idle_wr_o, "R13 reset outputs", busy_o, 0);
        rst = 0;
        @(negedge clk);
        chk(conv_gain_o == 3'd1 && !busy_o, "R13 default gain", int'(conv_gain_o), 1);

        // first cycle keeps the default gain though 6 is requested (R8, R13)
        run_cycle(0, 0, 6, 1, 0, -1, 0);

        // sweep of flows, averaging, data sets and operation modes
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 2; b++) begin
                    if (!(m == 3 && b == 1))
                        run_cycle(m, a, (m * 8 + a * 2 + b) % 8, (a + b) % 2, b[0], -1, 0);
                end
            end
        end

        // overflow flags, then recovery (R3)
        run_cycle(0, 1, 2, 1, 0, 4, 0);
        run_cycle(1, 0, 3, 0, 0, 0, 0);
        run_cycle(1, 0, 4, 1, 0, -1, 0);
        run_cycle(2, 2, 5, 0, 0, 13, 0);
        run_cycle(0, 0, 5, 1, 0, -1, 0);

        // start and tick while busy (R11)
        run_cycle(0, 1, 7, 1, 0, -1, 1);
        run_cycle(2, 0, 1, 0, 0, -1, 1);

        // idle operation ignores start and tick (R11)
        op_mode_i = 2'd2;
        clear_mon();
        @(negedge clk); start_i = 1; rate_tick_i = 1;
        @(negedge clk); start_i = 0; rate_tick_i = 0;
        repeat (30) @(negedge clk);
        chk(nlog == 0 && n_done == 0 && !busy_o, "R11 idle op ignored", nlog + n_done, 0);
        op_mode_i = 2'd3;
        @(negedge clk); start_i = 1; rate_tick_i = 1;
        @(negedge clk); start_i = 0; rate_tick_i = 0;
        repeat (30) @(negedge clk);
        chk(nlog == 0 && n_done == 0 && !busy_o, "R11 idle op ignored", nlog + n_done, 0);

        // single operation ignores the rate tick (R11)
        op_mode_i = 2'd1;
        @(negedge clk); rate_tick_i = 1;
        @(negedge clk); rate_tick_i = 0;
        repeat (30) @(negedge clk);
        chk(nlog == 0 && n_done == 0, "R11 tick in single ignored", nlog + n_done, 0);

        // continuous back-to-back ticks (R10)
        run_cycle(0, 2, 3, 0, 1, -1, 0);
        run_cycle(1, 1, 6, 0, 0, -1, 0);

        report();
    end
endmodule